// File: doc/BRIEF.md
# Set/Clear Control Register Bank with Strap Protection

This block is a 32-bit word-addressed register bank for reset-control, clock-stop and strap words in a system control area. A reset-control or clock-stop word is never overwritten directly. A write to its data address ORs the written bits in. A write to the address one word higher clears every bit that is set in the written value. Software can therefore raise or drop individual control bits without a read-modify-write.

The two strap words follow the same set/clear pairing. Each also has a protect word two words above it. While the protect word is nonzero, set writes to its strap word are dropped. The bank also holds:
- PLL extension words, whose lock bit always reads as 1;
- read-only revision, chip-ID and random-data words, which discard writes;
- plain read/write storage at every other word.

The port carries word indices (byte offset divided by 4). It accepts one request per cycle, either a read or a write. A read response appears one cycle after the request.

Top module: `sysctl_setclr_bank`

## Requirements
- R1: A write to a reset-control or clock-stop data word (byte offsets 0x40, 0x50, 0x80, 0x90; word indices 16, 20, 32, 36) leaves that word equal to its old value OR the written data.
- R2: A write to the word directly above one of those data words (0x44, 0x54, 0x84, 0x94) clears, in the data word below, every bit that is 1 in the written data. The clear words themselves store nothing and read as 0.
- R3: The strap words at 0x500 and 0x510 take OR-writes the same way. Writes to 0x504 and 0x514 clear bits in them, and this clearing works whatever the protect word holds.
- R4: A set write to a strap word is dropped while its protect word is nonzero (0x508 guards 0x500, 0x518 guards 0x510). The protect words are plain read/write storage.
- R5: Reads of the PLL extension words 0x204, 0x224 and 0x244 return bit 31 as 1 and bits 30:0 as stored.
- R6: Writes to 0x04, 0x14, 0x540, 0x5B0 and 0x5B4 leave the stored value unchanged.
- R7: After reset:
  - 0x40 reads 0xF7C3FED8;
  - 0x50 reads 0x0DFFFFFC;
  - 0x80 reads 0xFFFF7F8A;
  - 0x90 reads 0xFFF0FFF0;
  - 0x5B0 reads 0x1234ABCD;
  - 0x5B4 reads 0x88884444;
  - every word not covered by R8 and not listed here reads 0, apart from the forced bit of R5.
- R8: Reset loads 0x04 with the parameter REV_FIXED (default 0x00000301), 0x14 from `rev_b_in`, 0x500 from `strap_a_in` and 0x510 from `strap_b_in`.
- R9: Every other word, 0x00 included, is plain storage: a write replaces it fully, with no unlock needed.
- R10: `rsp_valid` is 1 exactly in the cycle after a read request, with that read's data. A write is visible to a read issued in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | IDX_W (10) | Word index (byte offset / 4) |
| req_wdata | input | 32 | Write data |
| strap_a_in | input | 32 | Value loaded into strap word 0x500 at reset |
| strap_b_in | input | 32 | Value loaded into strap word 0x510 at reset |
| rev_b_in | input | 32 | Value loaded into revision word 0x14 at reset |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |

## Verification
A write is committed at the rising edge where it is presented. A read response is registered at the rising edge where its request is presented, so it is due one cycle after the request. The bench drives every request on a falling edge and samples `rsp_valid` and `rsp_rdata` on the next falling edge. It issues the read that checks a write in the cycle right after that write, which exercises the tightest write-to-read spacing. After each write it also confirms that no response is flagged.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int unsigned DATA_W = 32;

    // word indices (byte offset / 4) whose behaviour depends on position
    localparam int unsigned W_REV_A   = 1;
    localparam int unsigned W_REV_B   = 5;
    localparam int unsigned W_RST_A   = 16;
    localparam int unsigned W_RST_B   = 20;
    localparam int unsigned W_CLK_A   = 32;
    localparam int unsigned W_CLK_B   = 36;
    localparam int unsigned W_PLLX_H  = 129;
    localparam int unsigned W_PLLX_M  = 137;
    localparam int unsigned W_PLLX_E  = 145;
    localparam int unsigned W_STRAP_A = 320;
    localparam int unsigned W_STRAP_B = 324;
    localparam int unsigned W_RNG     = 336;
    localparam int unsigned W_ID_A    = 364;
    localparam int unsigned W_ID_B    = 365;

    // distance from a strap word to its protect word
    localparam int unsigned PROT_OFS  = 2;

    typedef enum logic [2:0] {
        K_PLAIN     = 3'd0,
        K_SET       = 3'd1,
        K_CLR       = 3'd2,
        K_STRAP_SET = 3'd3,
        K_RO        = 3'd4
    } wkind_e;

    typedef struct packed {
        wkind_e      kind;
        logic [31:0] tgt;   // word actually updated
        logic [31:0] prot;  // protect word for strap sets
    } wdec_t;

    function automatic logic is_set_word(logic [31:0] w);
        return (w == W_RST_A) || (w == W_RST_B) || (w == W_CLK_A) || (w == W_CLK_B);
    endfunction

    function automatic logic is_strap_word(logic [31:0] w);
        return (w == W_STRAP_A) || (w == W_STRAP_B);
    endfunction

    function automatic logic is_ro_word(logic [31:0] w);
        return (w == W_REV_A) || (w == W_REV_B) || (w == W_RNG) ||
               (w == W_ID_A)  || (w == W_ID_B);
    endfunction

    function automatic logic is_pll_ext(logic [31:0] w);
        return (w == W_PLLX_H) || (w == W_PLLX_M) || (w == W_PLLX_E);
    endfunction

    function automatic wdec_t classify(logic [31:0] w);
        wdec_t d;
        d.tgt  = w;
        d.prot = w + PROT_OFS;
        if (is_set_word(w))                d.kind = K_SET;
        else if (is_strap_word(w))         d.kind = K_STRAP_SET;
        else if (is_set_word(w - 32'd1) || is_strap_word(w - 32'd1)) begin
            d.kind = K_CLR;
            d.tgt  = w - 32'd1;
        end
        else if (is_ro_word(w))            d.kind = K_RO;
        else                               d.kind = K_PLAIN;
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] reset_default(logic [31:0] w);
        case (w)
            W_RST_A: return 32'hF7C3_FED8;
            W_RST_B: return 32'h0DFF_FFFC;
            W_CLK_A: return 32'hFFFF_7F8A;
            W_CLK_B: return 32'hFFF0_FFF0;
            W_ID_A:  return 32'h1234_ABCD;
            W_ID_B:  return 32'h8888_4444;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/sysctl_wr_decode.sv
module sysctl_wr_decode
    import sysctl_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0] word,
    output wkind_e           kind,
    output logic [IDX_W-1:0] tgt,
    output logic [IDX_W-1:0] prot
);
    wdec_t d;

    always_comb begin
        d    = classify(32'(word));
        kind = d.kind;
        tgt  = d.tgt[IDX_W-1:0];
        prot = d.prot[IDX_W-1:0];
    end
endmodule

// File: rtl/sysctl_wr_merge.sv
module sysctl_wr_merge
    import sysctl_pkg::*;
#(
    parameter int W = 32
) (
    input  wkind_e       kind,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] prot_val,
    output logic         upd,
    output logic [W-1:0] nval
);
    always_comb begin
        upd  = 1'b0;
        nval = cur;
        unique case (kind)
            K_PLAIN: begin
                upd  = 1'b1;
                nval = wdata;
            end
            K_SET: begin
                upd  = 1'b1;
                nval = cur | wdata;
            end
            K_CLR: begin
                upd  = 1'b1;
                nval = cur & ~wdata;
            end
            K_STRAP_SET: begin
                upd  = (prot_val == '0);
                nval = cur | wdata;
            end
            default: begin
                upd  = 1'b0;
                nval = cur;
            end
        endcase
    end
endmodule

// File: rtl/sysctl_rd_port.sv
module sysctl_rd_port #(
    parameter int W        = 32,
    parameter int LOCK_BIT = W - 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd_fire,
    input  logic         force_lock,
    input  logic [W-1:0] stored,
    output logic         rsp_valid,
    output logic [W-1:0] rsp_rdata
);
    logic [W-1:0] lock_mask;
    logic         lock_q;

    always_comb begin
        lock_mask = '0;
        lock_mask[LOCK_BIT] = force_lock;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            lock_q    <= 1'b0;
        end else begin
            rsp_valid <= rd_fire;
            lock_q    <= rd_fire && force_lock;
            if (rd_fire) rsp_rdata <= stored | lock_mask;
        end
    end

    // R5: a forced-lock read never returns the lock bit low
    p_lock_bit_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && lock_q) |-> rsp_rdata[LOCK_BIT]);

    // R10: response exactly one cycle after each read request
    p_rsp_timing_r10: assert property (@(posedge clk) disable iff (rst)
        rd_fire |=> rsp_valid);
    p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_fire |=> !rsp_valid);
endmodule

// File: rtl/sysctl_setclr_bank.sv
module sysctl_setclr_bank
    import sysctl_pkg::*;
#(
    parameter int              IDX_W     = 10,
    parameter int              W         = sysctl_pkg::DATA_W,
    parameter logic [W-1:0]    REV_FIXED = 32'h0000_0301
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [IDX_W-1:0] req_word,
    input  logic [W-1:0]     req_wdata,
    input  logic [W-1:0]     strap_a_in,
    input  logic [W-1:0]     strap_b_in,
    input  logic [W-1:0]     rev_b_in,
    output logic             rsp_valid,
    output logic [W-1:0]     rsp_rdata
);
    localparam int NUM_WORDS = 1 << IDX_W;

    logic [W-1:0] regs [NUM_WORDS];

    wkind_e           wkind;
    logic [IDX_W-1:0] wtgt;
    logic [IDX_W-1:0] wprot;
    logic             upd;
    logic [W-1:0]     nval;
    logic             wr_fire;
    logic             rd_fire;

    assign wr_fire = req_valid &&  req_write;
    assign rd_fire = req_valid && !req_write;

    sysctl_wr_decode #(.IDX_W(IDX_W)) u_dec (
        .word (req_word),
        .kind (wkind),
        .tgt  (wtgt),
        .prot (wprot)
    );

    sysctl_wr_merge #(.W(W)) u_merge (
        .kind     (wkind),
        .cur      (regs[wtgt]),
        .wdata    (req_wdata),
        .prot_val (regs[wprot]),
        .upd      (upd),
        .nval     (nval)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_WORDS; i++) regs[i] <= reset_default(32'(i));
            regs[W_REV_A]   <= REV_FIXED;
            regs[W_REV_B]   <= rev_b_in;
            regs[W_STRAP_A] <= strap_a_in;
            regs[W_STRAP_B] <= strap_b_in;
        end else if (wr_fire && upd) begin
            regs[wtgt] <= nval;
        end
    end

    sysctl_rd_port #(.W(W)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .rd_fire    (rd_fire),
        .force_lock (is_pll_ext(32'(req_word))),
        .stored     (regs[req_word]),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    // record of the previous write, kept for the checks below
    logic             chk_v_q;
    wkind_e           chk_kind_q;
    logic [IDX_W-1:0] chk_tgt_q;
    logic [W-1:0]     chk_old_q;
    logic [W-1:0]     chk_data_q;
    logic [W-1:0]     chk_prot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_v_q    <= 1'b0;
            chk_kind_q <= K_PLAIN;
            chk_tgt_q  <= '0;
            chk_old_q  <= '0;
            chk_data_q <= '0;
            chk_prot_q <= '0;
        end else begin
            chk_v_q    <= wr_fire;
            chk_kind_q <= wkind;
            chk_tgt_q  <= wtgt;
            chk_old_q  <= regs[wtgt];
            chk_data_q <= req_wdata;
            chk_prot_q <= regs[wprot];
        end
    end

    p_set_or_r1: assert property (@(posedge clk) disable iff (rst)
        (chk_v_q && chk_kind_q == K_SET) |-> regs[chk_tgt_q] == (chk_old_q | chk_data_q));

    p_clear_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (chk_v_q && chk_kind_q == K_CLR) |-> regs[chk_tgt_q] == (chk_old_q & ~chk_data_q));

    p_strap_guard_r4: assert property (@(posedge clk) disable iff (rst)
        (chk_v_q && chk_kind_q == K_STRAP_SET && chk_prot_q != '0) |-> regs[chk_tgt_q] == chk_old_q);

    p_strap_open_r3: assert property (@(posedge clk) disable iff (rst)
        (chk_v_q && chk_kind_q == K_STRAP_SET && chk_prot_q == '0) |-> regs[chk_tgt_q] == (chk_old_q | chk_data_q));

    p_ro_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (chk_v_q && chk_kind_q == K_RO) |-> regs[chk_tgt_q] == chk_old_q);

    p_plain_store_r9: assert property (@(posedge clk) disable iff (rst)
        (chk_v_q && chk_kind_q == K_PLAIN) |-> regs[chk_tgt_q] == chk_data_q);
endmodule

// File: tb/sysctl_setclr_bank_tb.sv
module sysctl_setclr_bank_tb;
    localparam int IDX_W = 10;
    localparam int NW    = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_write = 1'b0;
    logic [IDX_W-1:0] req_word  = '0;
    logic [31:0]      req_wdata = '0;
    logic [31:0]      strap_a_in = 32'h0000_00F0;
    logic [31:0]      strap_b_in = 32'h0000_1000;
    logic [31:0]      rev_b_in   = 32'hA5A5_0102;
    logic             rsp_valid;
    logic [31:0]      rsp_rdata;

    int total = 0;
    int bad   = 0;
    logic [31:0] m [NW];

    always #10 clk = ~clk;

    sysctl_setclr_bank #(.IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_wdata(req_wdata), .strap_a_in(strap_a_in),
        .strap_b_in(strap_b_in), .rev_b_in(rev_b_in),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    function automatic bit in_set(int w);  return w == 16 || w == 20 || w == 32 || w == 36; endfunction
    function automatic bit in_strap(int w); return w == 320 || w == 324; endfunction
    function automatic bit in_ro(int w);   return w == 1 || w == 5 || w == 336 || w == 364 || w == 365; endfunction
    function automatic bit in_pll(int w);  return w == 129 || w == 137 || w == 145; endfunction

    function automatic logic [31:0] exp_read(int w);
        return m[w] | (in_pll(w) ? 32'h8000_0000 : 32'h0);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NW; i++) m[i] = '0;
        m[16] = 32'hF7C3_FED8; m[20] = 32'h0DFF_FFFC;
        m[32] = 32'hFFFF_7F8A; m[36] = 32'hFFF0_FFF0;
        m[364] = 32'h1234_ABCD; m[365] = 32'h8888_4444;
        m[1] = 32'h0000_0301; m[5] = rev_b_in;
        m[320] = strap_a_in; m[324] = strap_b_in;
    endtask

    task automatic model_write(int w, logic [31:0] d);
        if (in_set(w)) m[w] = m[w] | d;
        else if (in_strap(w)) begin
            if (m[w+2] == 0) m[w] = m[w] | d;
        end
        else if (in_set(w-1) || in_strap(w-1)) m[w-1] = m[w-1] & ~d;
        else if (in_ro(w)) begin end
        else m[w] = d;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(int w, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_word = w[IDX_W-1:0]; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        model_write(w, d);
    endtask

    task automatic rd_chk(string req, int w);
        req_valid = 1'b1; req_write = 1'b0; req_word = w[IDX_W-1:0];
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {31'd0, rsp_valid}, 32'd1);
        check(req, rsp_rdata, exp_read(w));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL R10 watchdog act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd2024);
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state: R7, R8
        check("R10 idle after reset", {31'd0, rsp_valid}, 32'd0);
        rd_chk("R7 rst word 0x40", 16);
        rd_chk("R7 rst word 0x50", 20);
        rd_chk("R7 clk word 0x80", 32);
        rd_chk("R7 clk word 0x90", 36);
        rd_chk("R7 chip id 0x5B0", 364);
        rd_chk("R7 chip id 0x5B4", 365);
        rd_chk("R7 plain zero", 600);
        check("R7 plain literal", rsp_rdata, 32'h0);
        rd_chk("R8 rev fixed", 1);
        rd_chk("R8 rev input", 5);
        rd_chk("R8 strap a", 320);
        rd_chk("R8 strap b", 324);

        // R1 set semantics
        wr(16, 32'h0800_0007);
        check("R10 no rsp after write", {31'd0, rsp_valid}, 32'd0);
        rd_chk("R1 or into 0x40", 16);
        check("R1 literal", rsp_rdata, 32'hFFC3_FEDF);
        wr(36, 32'h000F_000F);
        rd_chk("R1 or into 0x90", 36);

        // R2 clear semantics
        wr(17, 32'hF000_0000);
        rd_chk("R2 clear 0x40", 16);
        check("R2 literal", rsp_rdata, 32'h0FC3_FEDF);
        rd_chk("R2 clear word reads 0", 17);
        wr(33, 32'hFFFF_FFFF);
        rd_chk("R2 clear all 0x80", 32);
        check("R2 all cleared", rsp_rdata, 32'h0);

        // R3 / R4 strap behaviour
        wr(320, 32'h0000_0F00);
        rd_chk("R3 strap or", 320);
        check("R3 strap literal", rsp_rdata, 32'h0000_0FF0);
        wr(321, 32'h0000_00F0);
        rd_chk("R3 strap clear", 320);
        wr(322, 32'h0000_0001);
        wr(320, 32'hFFFF_0000);
        rd_chk("R4 protected set dropped", 320);
        check("R4 literal", rsp_rdata, 32'h0000_0F00);
        rd_chk("R4 protect word stored", 322);
        wr(321, 32'h0000_0300);
        rd_chk("R3 clear while protected", 320);
        wr(324, 32'h0000_0002);
        rd_chk("R4 other strap unguarded", 324);
        wr(322, 32'h0);
        wr(320, 32'h0000_0001);
        rd_chk("R4 unprotected again", 320);

        // R5 PLL lock bit
        wr(137, 32'h1234_5678);
        rd_chk("R5 lock forced", 137);
        check("R5 literal", rsp_rdata, 32'h9234_5678);
        wr(129, 32'h0);
        rd_chk("R5 lock on zero", 129);
        wr(128, 32'h0);
        rd_chk("R5 neighbour not forced", 128);

        // R6 read-only words
        wr(1, 32'hDEAD_BEEF);   rd_chk("R6 rev a", 1);
        wr(5, 32'hDEAD_BEEF);   rd_chk("R6 rev b", 5);
        wr(336, 32'h1111_2222); rd_chk("R6 rng", 336);
        wr(364, 32'h0);         rd_chk("R6 id a", 364);
        wr(365, 32'h0);         rd_chk("R6 id b", 365);

        // R9 plain storage
        wr(0, 32'hCAFE_F00D);   rd_chk("R9 key word plain", 0);
        wr(192, 32'h1357_9BDF); rd_chk("R9 plain", 192);
        wr(192, 32'h0000_0001); rd_chk("R9 full replace", 192);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int pick;
            int w;
            logic [31:0] d;
            pick = int'($urandom_range(0, 24));
            case (pick)
                0: w = 16;  1: w = 17;  2: w = 20;  3: w = 21;
                4: w = 32;  5: w = 33;  6: w = 36;  7: w = 37;
                8: w = 320; 9: w = 321; 10: w = 322; 11: w = 324;
                12: w = 325; 13: w = 326; 14: w = 129; 15: w = 137;
                16: w = 145; 17: w = 1; 18: w = 5; 19: w = 336;
                20: w = 364; 21: w = 365; 22: w = 0;
                default: w = int'($urandom_range(0, NW - 1));
            endcase
            d = $urandom();
            if ((w == 322 || w == 326) && $urandom_range(0, 1) == 0) d = 32'h0;
            if ($urandom_range(0, 1) == 0) wr(w, d);
            else rd_chk("R1 R2 R3 R4 R5 R6 R9 random", w);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule